// File: doc/BRIEF.md
# Transmit Flow-Control Update Generator

This block sits beside a transmit streaming path and does two jobs. It passes or discards the beats of that stream according to an error-recovery policy. It also decides when the host should get a flow-control status report. A report is a one-cycle request strobe. With it come the configured stream identifier and the number of packets forwarded since the last clear. Message formatting is left to a downstream block.

Two independent triggers can request a report. One counts clock cycles. The other counts consumed channel groups, where a group is one packet per configured channel. Each trigger has its own limit and its own enable bit. Any report restarts both counters.

When the packet parser flags an error on a beat, the block follows the programmed policy. It can discard input up to the end of the packet, discard input up to the end of the burst, or stall the stream until software issues a clear. A clear pulse returns the block to its reset state at any time.

Top module: `fcu_update_gen`

## Requirements
- R1: After reset, `rpt_req` is low, the packet sequence count is zero and the stream is in pass state.
- R2: When `cfg_cyc_per_up` bit 31 is set and its low 31 bits hold N > 0, `rpt_req` pulses every N cycles, counting from the last report or clear. With no packet traffic the first pulse appears in the Nth cycle after a clear.
- R3: When `cfg_pkt_per_up` bit 31 is set and its low 31 bits hold M > 0, a report is requested once M channel groups have been forwarded. A group is `cfg_num_chan` packets, and a value of 0 counts as 1. The pulse appears in the cycle after the end-of-packet beat that completes the Mth group.
- R4: A trigger whose bit 31 is clear, or whose count field is 0, never requests a report.
- R5: If both triggers hit in the same cycle, exactly one report is issued. Any report restarts both counters from zero.
- R6: Each report carries `cfg_sid` as it was in the triggering cycle. It also carries the number of forwarded packets, counted by end-of-packet beats, since the last clear, including a packet ending in the triggering cycle.
- R7: In pass state with `in_err` low, `out_valid` equals `in_valid` and `in_ready` equals `out_ready`.
- R8: With `cfg_policy` = 3'b010 (skip to next packet), a beat accepted with `in_err` is discarded. If it is not an end-of-packet beat, the rest of that packet is also discarded with `in_ready` high. Forwarding resumes after the end-of-packet beat.
- R9: With `cfg_policy` = 3'b100 (skip to next burst), an error starts discarding that lasts through the next end-of-packet beat that also has `in_eob` set. End-of-packet beats without `in_eob` do not end the discard.
- R10: With `cfg_policy` bit 0 set (wait), or with the field all zero, an error beat stalls the stream: `in_ready` and `out_valid` stay low until a clear. When several bits are set, wait wins over skip-to-burst, which wins over skip-to-packet.
- R11: A one-cycle `cfg_clear` pulse returns the stream to pass state and zeroes both trigger counters, the channel-group position and the sequence count. It also suppresses any report in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously to `clk` |
| cfg_clear | input | 1 | One-cycle pulse that clears all state |
| cfg_num_chan | input | CHAN_W | Packets per channel group (0 is treated as 1) |
| cfg_sid | input | SID_W | Stream identifier placed in reports |
| cfg_policy | input | 3 | One-hot error policy: bit 0 wait, bit 1 next packet, bit 2 next burst |
| cfg_cyc_per_up | input | CNT_W+1 | Cycle trigger: top bit enable, low bits count |
| cfg_pkt_per_up | input | CNT_W+1 | Packet trigger: top bit enable, low bits group count |
| in_valid | input | 1 | Upstream beat valid |
| in_eop | input | 1 | Beat ends a packet |
| in_eob | input | 1 | Packet ends a burst (meaningful with `in_eop`) |
| in_err | input | 1 | Parser flags an error on this beat |
| in_ready | output | 1 | Block accepts the upstream beat |
| out_valid | output | 1 | Beat forwarded downstream |
| out_ready | input | 1 | Downstream accepts the beat |
| rpt_req | output | 1 | One-cycle report request |
| rpt_sid | output | SID_W | Stream identifier of the report |
| rpt_seq | output | SEQ_W | Forwarded packet count at the report |

## Verification
The assertions check the cycle-level properties on every cycle:
- the pass-through handshake,
- that a non-final discarded beat under a skip policy is followed by no forwarded beat,
- that a stall persists until a clear,
- that a clear or two disabled triggers give no report in the next cycle,
- that a report's identifier matches the previous cycle's configuration.

Only the bench's scenarios can show the following:
- the report period for a given limit,
- the channel-group counting and the carried sequence count,
- the restart of the cycle counter by a packet-triggered report,
- that burst discard outlives an end-of-packet without end-of-burst,
- the policy priority when several bits are set.

// File: rtl/fcu_pkg.sv
package fcu_pkg;
  typedef enum logic [1:0] {
    FS_PASS       = 2'd0,
    FS_DROP_PKT   = 2'd1,
    FS_DROP_BURST = 2'd2,
    FS_HALT       = 2'd3
  } fcu_state_e;

  // bit positions inside the policy field
  localparam int POL_WAIT  = 0;
  localparam int POL_PKT   = 1;
  localparam int POL_BURST = 2;
  localparam int POL_W     = 3;

  // trigger slots
  localparam int TRIG_CYC = 0;
  localparam int TRIG_PKT = 1;
  localparam int NUM_TRIG = 2;
endpackage

// File: rtl/fcu_trig_cnt.sv
module fcu_trig_cnt #(
  parameter int CNT_W = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             restart_i,
  input  logic             enable_i,
  input  logic [CNT_W-1:0] limit_i,
  input  logic             event_i,
  output logic             hit_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             active;

  assign active = enable_i && (limit_i != '0);
  assign hit_o  = active && event_i && (cnt_q == limit_i - ONE);

  always_comb begin
    cnt_d = cnt_q;
    if (clear_i || restart_i || !active) begin
      cnt_d = '0;
    end else if (event_i) begin
      cnt_d = cnt_q + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/fcu_policy_fsm.sv
module fcu_policy_fsm
  import fcu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic [POL_W-1:0] policy_i,
  input  logic             in_valid,
  input  logic             in_eop,
  input  logic             in_eob,
  input  logic             in_err,
  input  logic             out_ready,
  output logic             in_ready,
  output logic             out_valid
);
  fcu_state_e st_q, st_d;
  logic       beat;
  logic       burst_end;

  assign beat      = in_valid && in_ready;
  assign burst_end = in_eop && in_eob;

  always_comb begin
    out_valid = 1'b0;
    in_ready  = 1'b0;
    unique case (st_q)
      FS_PASS: begin
        out_valid = in_valid && !in_err;
        in_ready  = in_err ? 1'b1 : out_ready;
      end
      FS_DROP_PKT,
      FS_DROP_BURST: in_ready = 1'b1;
      default: ;
    endcase
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      FS_PASS: begin
        if (beat && in_err) begin
          if (policy_i[POL_WAIT] || (policy_i == '0)) begin
            st_d = FS_HALT;
          end else if (policy_i[POL_BURST]) begin
            st_d = burst_end ? FS_PASS : FS_DROP_BURST;
          end else begin
            st_d = in_eop ? FS_PASS : FS_DROP_PKT;
          end
        end
      end
      FS_DROP_PKT:   if (beat && in_eop)    st_d = FS_PASS;
      FS_DROP_BURST: if (beat && burst_end) st_d = FS_PASS;
      default: ;
    endcase
    if (clear_i) begin
      st_d = FS_PASS;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= FS_PASS;
    end else begin
      st_q <= st_d;
    end
  end
endmodule

// File: rtl/fcu_update_gen.sv
module fcu_update_gen
  import fcu_pkg::*;
#(
  parameter int CNT_W  = 31,
  parameter int SID_W  = 32,
  parameter int SEQ_W  = 16,
  parameter int CHAN_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_clear,
  input  logic [CHAN_W-1:0] cfg_num_chan,
  input  logic [SID_W-1:0]  cfg_sid,
  input  logic [POL_W-1:0]  cfg_policy,
  input  logic [CNT_W:0]    cfg_cyc_per_up,
  input  logic [CNT_W:0]    cfg_pkt_per_up,
  input  logic              in_valid,
  input  logic              in_eop,
  input  logic              in_eob,
  input  logic              in_err,
  output logic              in_ready,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              rpt_req,
  output logic [SID_W-1:0]  rpt_sid,
  output logic [SEQ_W-1:0]  rpt_seq
);
  localparam logic [CHAN_W-1:0] CH_ONE = CHAN_W'(1);

  // ---------------- stream policy ----------------
  fcu_policy_fsm u_pol (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_i   (cfg_clear),
    .policy_i  (cfg_policy),
    .in_valid  (in_valid),
    .in_eop    (in_eop),
    .in_eob    (in_eob),
    .in_err    (in_err),
    .out_ready (out_ready),
    .in_ready  (in_ready),
    .out_valid (out_valid)
  );

  // ---------------- packet / group tracking ----------------
  logic              fwd_eop, grp_done;
  logic [CHAN_W-1:0] chan_q, chan_d, last_chan;
  logic [SEQ_W-1:0]  seq_q, seq_d;

  assign fwd_eop   = out_valid && out_ready && in_eop;
  assign last_chan = (cfg_num_chan == '0) ? '0 : (cfg_num_chan - CH_ONE);
  assign grp_done  = fwd_eop && (chan_q >= last_chan);

  always_comb begin
    chan_d = chan_q;
    if (cfg_clear)    chan_d = '0;
    else if (fwd_eop) chan_d = grp_done ? '0 : (chan_q + CH_ONE);
    seq_d = cfg_clear ? '0 : (seq_q + SEQ_W'(fwd_eop));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_q <= '0;
      seq_q  <= '0;
    end else begin
      chan_q <= chan_d;
      seq_q  <= seq_d;
    end
  end

  // ---------------- update triggers ----------------
  logic [CNT_W:0]        trig_cfg [NUM_TRIG];
  logic [NUM_TRIG-1:0]   trig_evt;
  logic [NUM_TRIG-1:0]   trig_hit;
  logic                  rpt_fire;

  assign trig_cfg[TRIG_CYC] = cfg_cyc_per_up;
  assign trig_cfg[TRIG_PKT] = cfg_pkt_per_up;
  assign trig_evt[TRIG_CYC] = 1'b1;
  assign trig_evt[TRIG_PKT] = grp_done;
  assign rpt_fire           = |trig_hit;

  for (genvar g = 0; g < NUM_TRIG; g++) begin : g_trig
    fcu_trig_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear_i   (cfg_clear),
      .restart_i (rpt_fire),
      .enable_i  (trig_cfg[g][CNT_W]),
      .limit_i   (trig_cfg[g][CNT_W-1:0]),
      .event_i   (trig_evt[g]),
      .hit_o     (trig_hit[g])
    );
  end

  // ---------------- report request ----------------
  logic             rpt_load;
  logic [SEQ_W-1:0] rpt_seq_d;
  logic [SID_W-1:0] rpt_sid_d;

  always_comb begin
    rpt_load  = rpt_fire && !cfg_clear;
    rpt_seq_d = rpt_load ? (seq_q + SEQ_W'(fwd_eop)) : rpt_seq;
    rpt_sid_d = rpt_load ? cfg_sid : rpt_sid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rpt_req <= 1'b0;
      rpt_seq <= '0;
      rpt_sid <= '0;
    end else begin
      rpt_req <= rpt_load;
      rpt_seq <= rpt_seq_d;
      rpt_sid <= rpt_sid_d;
    end
  end
endmodule

// File: rtl/fcu_update_gen_chk.sv
module fcu_update_gen_chk
  import fcu_pkg::*;
#(
  parameter int CNT_W  = 31,
  parameter int SID_W  = 32,
  parameter int SEQ_W  = 16,
  parameter int CHAN_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_clear,
  input logic [CHAN_W-1:0] cfg_num_chan,
  input logic [SID_W-1:0]  cfg_sid,
  input logic [POL_W-1:0]  cfg_policy,
  input logic [CNT_W:0]    cfg_cyc_per_up,
  input logic [CNT_W:0]    cfg_pkt_per_up,
  input logic              in_valid,
  input logic              in_eop,
  input logic              in_eob,
  input logic              in_err,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic              rpt_req,
  input logic [SID_W-1:0]  rpt_sid,
  input logic [SEQ_W-1:0]  rpt_seq
);
  AST_PASS_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (in_valid && !in_err && (in_ready == out_ready))); // R7

  AST_SKIP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !out_valid && !in_eop && !cfg_clear &&
     (cfg_policy == 3'b010 || cfg_policy == 3'b100)) |=> !out_valid); // R8

  AST_STALL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && out_ready && !cfg_clear) |=> (!in_ready && !out_valid)); // R10

  AST_CLEAR_NO_RPT: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_clear |=> !rpt_req); // R11

  AST_DISABLED_NO_RPT: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_cyc_per_up[CNT_W] && !cfg_pkt_per_up[CNT_W]) |=> !rpt_req); // R4

  AST_RPT_SID: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_req |-> (rpt_sid == $past(cfg_sid))); // R6
endmodule

bind fcu_update_gen fcu_update_gen_chk #(
  .CNT_W(CNT_W), .SID_W(SID_W), .SEQ_W(SEQ_W), .CHAN_W(CHAN_W)
) u_chk (.*);

// File: tb/sim_fcu_update_gen.sv
`timescale 1ns/1ps
module sim_fcu_update_gen;
  localparam int CNT_W = 31, SID_W = 32, SEQ_W = 16, CHAN_W = 3;
  localparam logic [CNT_W:0] EN = {1'b1, {CNT_W{1'b0}}};

  logic clk, rst_n, cfg_clear;
  logic [CHAN_W-1:0] cfg_num_chan;
  logic [SID_W-1:0]  cfg_sid;
  logic [2:0]        cfg_policy;
  logic [CNT_W:0]    cfg_cyc_per_up, cfg_pkt_per_up;
  logic in_valid, in_eop, in_eob, in_err, in_ready, out_valid, out_ready, rpt_req;
  logic [SID_W-1:0]  rpt_sid;
  logic [SEQ_W-1:0]  rpt_seq;

  int total = 0, bad = 0;
  int np;
  int pos  [0:7];
  int seqs [0:7];
  logic [SID_W-1:0] sids [0:7];

  fcu_update_gen #(.CNT_W(CNT_W), .SID_W(SID_W), .SEQ_W(SEQ_W), .CHAN_W(CHAN_W)) u0 (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // {valid, eop, eob, err, out_ready, exp_out_valid, exp_in_ready}
  localparam logic [6:0] VEC [0:9] = '{
    7'b1000111, 7'b1100111, 7'b1001101, 7'b1000101, 7'b1100101,
    7'b1000010, 7'b1100111, 7'b1101101, 7'b1000111, 7'b0000101
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic drive(input logic v, input logic e, input logic b, input logic r, input logic o);
    in_valid = v; in_eop = e; in_eob = b; in_err = r; out_ready = o;
  endtask

  task automatic do_clear();
    cfg_clear = 1'b1; step(); cfg_clear = 1'b0;
  endtask

  // run n cycles, single-beat packets in the first npkt, record report pulses
  task automatic run(input int n, input int npkt);
    np = 0;
    for (int i = 0; i < n; i++) begin
      drive(i < npkt, i < npkt, 1'b0, 1'b0, 1'b1);
      step();
      if (rpt_req) begin
        if (np < 8) begin pos[np] = i; seqs[np] = int'(rpt_seq); sids[np] = rpt_sid; end
        np++;
      end
    end
    drive(0, 0, 0, 0, 1);
  endtask

  initial begin
    #200000;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_clear = 1'b0; cfg_num_chan = 3'd1; cfg_sid = 32'h0;
    cfg_policy = 3'b010; cfg_cyc_per_up = '0; cfg_pkt_per_up = '0;
    drive(0, 0, 0, 0, 1);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step();

    // R1 reset state
    chk("R1 rpt_req", rpt_req, 0);
    drive(1, 0, 0, 0, 1); #1;
    chk("R1 pass out_valid", out_valid, 1);
    chk("R1 pass in_ready", in_ready, 1);
    drive(0, 0, 0, 0, 1);
    cfg_pkt_per_up = EN | 32'd1; cfg_sid = 32'h1111_0001;
    run(2, 1);
    chk("R1 seq from zero", seqs[0], 1);
    chk("R1 pulse count", np, 1);

    // vector table: skip-to-next-packet policy, triggers off
    cfg_pkt_per_up = '0; cfg_policy = 3'b010; do_clear();
    for (int i = 0; i < 10; i++) begin
      drive(VEC[i][6], VEC[i][5], VEC[i][4], VEC[i][3], VEC[i][2]); #1;
      chk((i >= 2 && i <= 4) || i == 7 ? "R8 out_valid" : "R7 out_valid", out_valid, VEC[i][1]);
      chk((i >= 2 && i <= 4) || i == 7 ? "R8 in_ready" : "R7 in_ready", in_ready, VEC[i][0]);
      step();
    end
    drive(0, 0, 0, 0, 1);

    // R9 skip to next burst
    cfg_policy = 3'b100; do_clear();
    drive(1, 0, 0, 1, 1); #1; chk("R9 err beat dropped", out_valid, 0); step();
    drive(1, 1, 0, 0, 1); #1; chk("R9 eop w/o eob dropped", out_valid, 0);
    chk("R9 ready while dropping", in_ready, 1); step();
    drive(1, 0, 0, 0, 1); #1; chk("R9 still dropping", out_valid, 0); step();
    drive(1, 1, 1, 0, 1); #1; chk("R9 burst end dropped", out_valid, 0); step();
    drive(1, 0, 0, 0, 1); #1; chk("R9 resumes", out_valid, 1); step();

    // R10 wait policy and priority
    cfg_policy = 3'b001; do_clear();
    drive(1, 0, 0, 1, 1); step();
    drive(1, 0, 0, 0, 1);
    for (int i = 0; i < 3; i++) begin
      #1; chk("R10 stalled in_ready", in_ready, 0); chk("R10 stalled out_valid", out_valid, 0); step();
    end
    cfg_clear = 1'b1; step(); cfg_clear = 1'b0; #1;
    chk("R11 clear leaves stall", in_ready, 1);
    chk("R11 clear forwards", out_valid, 1);
    cfg_policy = 3'b000; drive(1, 1, 0, 1, 1); step(); drive(1, 0, 0, 0, 1); #1;
    chk("R10 zero policy stalls", in_ready, 0);
    cfg_policy = 3'b011; do_clear(); drive(1, 1, 0, 1, 1); step(); drive(1, 0, 0, 0, 1); #1;
    chk("R10 wait beats packet", in_ready, 0);
    cfg_policy = 3'b110; do_clear(); drive(1, 1, 0, 1, 1); step();
    drive(1, 1, 0, 0, 1); #1; chk("R10 burst beats packet", out_valid, 0); step();
    drive(0, 0, 0, 0, 1); cfg_policy = 3'b010; do_clear();

    // R2 cycle trigger period
    cfg_sid = 32'hCAFE_0002; cfg_cyc_per_up = EN | 32'd5; do_clear();
    run(30, 0);
    chk("R2 pulse count", np, 6);
    chk("R2 first pulse", pos[0], 4);
    chk("R2 period", pos[1] - pos[0], 5);
    chk("R6 sid carried", sids[0], 32'hCAFE_0002);

    // R11 clear restarts counter
    do_clear(); run(3, 0); do_clear(); run(6, 0);
    chk("R11 first pulse after clear", pos[0], 4);

    // R4 disabled triggers
    cfg_cyc_per_up = 32'd5; cfg_pkt_per_up = 32'd1; do_clear();
    run(12, 10);
    chk("R4 no enable", np, 0);
    cfg_cyc_per_up = EN; cfg_pkt_per_up = EN; do_clear();
    run(12, 10);
    chk("R4 zero count", np, 0);

    // R3 packet trigger with channel groups
    cfg_cyc_per_up = '0; cfg_num_chan = 3'd2; cfg_pkt_per_up = EN | 32'd3;
    cfg_sid = 32'h0000_00A5; do_clear();
    run(13, 12);
    chk("R3 pulse count", np, 2);
    chk("R3 first pulse", pos[0], 5);
    chk("R6 seq at first", seqs[0], 6);
    chk("R6 seq at second", seqs[1], 12);
    chk("R6 sid", sids[1], 32'hA5);
    cfg_num_chan = 3'd0; cfg_pkt_per_up = EN | 32'd2; do_clear();
    run(5, 4);
    chk("R3 zero chan count", np, 2);
    chk("R3 zero chan seq", seqs[1], 4);

    // R5 report restarts both counters
    cfg_num_chan = 3'd1; cfg_cyc_per_up = EN | 32'd4; cfg_pkt_per_up = EN | 32'd3; do_clear();
    run(12, 3);
    chk("R5 packet pulse", pos[0], 2);
    chk("R5 cycle restarted", pos[1], 6);
    cfg_cyc_per_up = EN | 32'd3; do_clear();
    run(12, 3);
    chk("R5 coincident single", np, 4);
    chk("R5 next after coincident", pos[1], 5);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule